// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment value and an offset into a linear memory address. A mode input selects one of two ways of forming the address. In real mode the segment value is scaled by sixteen and added to a 16-bit offset, which gives an address inside a 1 MB window. In protected mode the segment value is a selector. The selector picks one descriptor from one of two small on-chip tables: a global table and a local table. The unit checks the offset against that descriptor's limit and its present bit. If both checks pass, it adds the descriptor base to the offset. If a check fails, it returns a fault code in place of an address.

Both descriptor tables are loaded through a single write port, one whole descriptor per cycle. Requests use a valid/ready handshake and take one cycle. A response stays registered until the consumer takes it, and a new request is accepted only while the response slot is free or is being drained.

Top module: `seg_xlate`

## Requirements
- R1: With `req_prot`=0 the response address is (`req_seg`*16 + `req_off[15:0]`) mod 2^20. Address bits 31:20 are zero, `rsp_code` is 0, and `req_off[31:16]` and the tables have no effect.
- R2: With `req_prot`=1 the selector is decoded as follows. Bit 2 chooses the table (0 = global, 1 = local). Bits 5:3 index one of its 8 entries. Bits 1:0 are ignored. The response address is (descriptor base + effective offset) mod 2^32.
- R3: In protected mode `req_wide`=1 makes the effective offset all 32 bits of `req_off`. `req_wide`=0 makes it `req_off[15:0]` zero-extended.
- R4: When the effective offset is greater than the descriptor's 20-bit limit, `rsp_code` is 3 (limit fault). An offset equal to the limit is accepted.
- R5: When bit 7 of the descriptor's access byte (the present bit) is clear, `rsp_code` is 2 (not-present fault).
- R6: A global-table selector with index 0 gives `rsp_code` 1 (null fault), whatever that entry holds. Local index 0 translates normally.
- R7: A selector with any of bits 15:6 set lies beyond the 8-entry table and gives `rsp_code` 3. Faults are ranked null first, then table range, then not-present, then offset limit.
- R8: Whenever `rsp_code` is nonzero, `rsp_addr` is 0.
- R9: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high, and it appears with `rsp_valid` high after that edge. `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable.
- R10: When `tbl_we` is high, the descriptor on the write port is stored at edge into table `tbl_sel` (0 = global) at entry `tbl_idx`. A request accepted at the same edge sees the previous contents. Reset clears every entry, so every entry reads not present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_sel | input | 1 | Target table: 0 global, 1 local |
| tbl_idx | input | 3 | Target entry |
| tbl_base | input | 32 | Descriptor base address |
| tbl_limit | input | 20 | Descriptor limit (largest legal offset) |
| tbl_acc | input | 8 | Access byte, bit 7 = present |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_wide | input | 1 | Protected mode: 1 = 32-bit offset, 0 = 16-bit offset |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Linear address, 0 on fault |
| rsp_code | output | 2 | 0 none, 1 null, 2 not present, 3 limit/range |

## Verification
The hardest case to reach is a request that hits a table entry in the same cycle that entry is being rewritten. The bench drives the write strobe and the request on the same falling edge and expects the old descriptor. It then sends a second request to the same entry and expects the new one. A second awkward case is back-pressure. The bench holds `rsp_ready` low for several cycles while a new request waits at the input, and it checks that the held response does not change and that the waiting request is taken only once the slot drains.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEG_W       = 16;
  localparam int ADDR_W      = 32;
  localparam int REAL_W      = 20;
  localparam int DLIM_W      = 20;
  localparam int DACC_W      = 8;
  localparam int SEL_TI_BIT  = 2;
  localparam int SEL_IDX_LSB = 3;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_NULL   = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_LIMIT  = 2'd3
  } flt_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [DLIM_W-1:0] limit;
    logic [DACC_W-1:0] acc;
  } desc_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  desc_t            wdesc,
  input  logic [IDX_W-1:0] ridx,
  output desc_t            rdesc
);
  localparam int ENTRIES = 1 << IDX_W;

  desc_t mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (ent_en) mem_q[g] <= wdesc;
    end
  end

  assign rdesc = mem_q[ridx];
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int PRES_BIT = 7
) (
  input  logic              prot,
  input  logic              wide,
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] off,
  input  desc_t             desc,
  output logic [ADDR_W-1:0] addr,
  output flt_e              code
);
  localparam int HI_LSB = SEL_IDX_LSB + IDX_W;

  logic [REAL_W-1:0] real_sum;
  logic [ADDR_W-1:0] off_eff;
  logic              is_null, out_rng, absent, over;

  always_comb begin
    real_sum = {seg, 4'b0000} + {{(REAL_W-16){1'b0}}, off[15:0]};
    off_eff  = wide ? off : {{(ADDR_W-16){1'b0}}, off[15:0]};
    is_null  = (seg[SEG_W-1:SEL_TI_BIT] == '0);
    out_rng  = (seg[SEG_W-1:HI_LSB] != '0);
    absent   = !desc.acc[PRES_BIT];
    over     = off_eff > {{(ADDR_W-DLIM_W){1'b0}}, desc.limit};

    if (!prot)        code = FLT_NONE;
    else if (is_null) code = FLT_NULL;
    else if (out_rng) code = FLT_LIMIT;
    else if (absent)  code = FLT_ABSENT;
    else if (over)    code = FLT_LIMIT;
    else              code = FLT_NONE;

    if (!prot)                 addr = {{(ADDR_W-REAL_W){1'b0}}, real_sum};
    else if (code == FLT_NONE) addr = desc.base + off_eff;
    else                       addr = '0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int PRES_BIT = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic                    tbl_sel,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic [ADDR_W-1:0]       tbl_base,
  input  logic [DLIM_W-1:0]       tbl_limit,
  input  logic [DACC_W-1:0]       tbl_acc,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_prot,
  input  logic                    req_wide,
  input  logic [SEG_W-1:0]        req_seg,
  input  logic [ADDR_W-1:0]       req_off,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [ADDR_W-1:0]       rsp_addr,
  output logic [1:0]              rsp_code
);
  localparam int NTBL = 2;

  desc_t wdesc;
  desc_t rdesc [NTBL];
  desc_t sel_desc;

  assign wdesc = '{base: tbl_base, limit: tbl_limit, acc: tbl_acc};

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic t_we;
    assign t_we = tbl_we && (tbl_sel == 1'(t));
    seg_desc_table #(.IDX_W(IDX_W)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (t_we),
      .widx  (tbl_idx),
      .wdesc (wdesc),
      .ridx  (req_seg[SEL_IDX_LSB +: IDX_W]),
      .rdesc (rdesc[t])
    );
  end

  assign sel_desc = rdesc[req_seg[SEL_TI_BIT]];

  logic [ADDR_W-1:0] calc_addr;
  flt_e              calc_code;

  seg_xlate_calc #(.IDX_W(IDX_W), .PRES_BIT(PRES_BIT)) u_calc (
    .prot (req_prot),
    .wide (req_wide),
    .seg  (req_seg),
    .off  (req_off),
    .desc (sel_desc),
    .addr (calc_addr),
    .code (calc_code)
  );

  // response slot: next-state and register
  logic              accept;
  logic              vld_d, vld_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  flt_e              code_d, code_q;
  logic              load_en;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    vld_d   = vld_q;
    load_en = accept;
    addr_d  = calc_addr;
    code_d  = calc_code;
    if (accept)         vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      code_q <= FLT_NONE;
    end else if (load_en) begin
      addr_q <= addr_d;
      code_q <= code_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_addr  = addr_q;
  assign rsp_code  = code_q;

  AST_REAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_prot) |=> (rsp_valid && rsp_addr[ADDR_W-1:REAL_W] == '0 && rsp_code == 2'd0)); // R1
  AST_NULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_prot && req_seg[SEG_W-1:SEL_TI_BIT] == '0) |=> (rsp_code == 2'd1)); // R6
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_addr == '0)); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_code))); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_RANGE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_prot && req_seg[SEG_W-1:SEL_IDX_LSB+IDX_W] != '0) |=> (rsp_code == 2'd3)); // R7
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        tbl_we, tbl_sel;
  logic [2:0]  tbl_idx;
  logic [31:0] tbl_base;
  logic [19:0] tbl_limit;
  logic [7:0]  tbl_acc;
  logic        req_valid, req_ready, req_prot, req_wide;
  logic [15:0] req_seg;
  logic [31:0] req_off;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_code;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_base [2][8];
  logic [19:0] m_lim  [2][8];
  logic [7:0]  m_acc  [2][8];

  seg_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit), .tbl_acc(tbl_acc),
    .req_valid(req_valid), .req_ready(req_ready), .req_prot(req_prot),
    .req_wide(req_wide), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_code(rsp_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model: returns {code, addr}
  function automatic logic [33:0] model(input logic prot, input logic wide,
                                        input logic [15:0] seg, input logic [31:0] off);
    logic [31:0] oe;
    logic [19:0] r;
    int t, i;
    if (!prot) begin
      r = 20'(seg) * 20'd16 + 20'(off[15:0]);
      return {2'd0, 12'd0, r};
    end
    oe = wide ? off : {16'd0, off[15:0]};
    t  = int'(seg[2]);
    i  = int'(seg[5:3]);
    if (seg[15:2] == 14'd0)           return {2'd1, 32'd0};
    if (seg[15:6] != 10'd0)           return {2'd3, 32'd0};
    if (!m_acc[t][i][7])              return {2'd2, 32'd0};
    if (oe > {12'd0, m_lim[t][i]})    return {2'd3, 32'd0};
    return {2'd0, m_base[t][i] + oe};
  endfunction

  task automatic wr(input logic t, input logic [2:0] i, input logic [31:0] b,
                    input logic [19:0] l, input logic [7:0] a);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = t; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_acc = a;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[t][i] = b; m_lim[t][i] = l; m_acc[t][i] = a;
  endtask

  task automatic xl(input string req, input logic prot, input logic wide,
                    input logic [15:0] seg, input logic [31:0] off);
    logic [33:0] e;
    e = model(prot, wide, seg, off);
    @(negedge clk);
    req_valid = 1'b1; req_prot = prot; req_wide = wide; req_seg = seg; req_off = off;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " code"},  64'(rsp_code), 64'(e[33:32]));
    check({req, " addr"},  64'(rsp_addr), 64'(e[31:0]));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [33:0] e1, e2;
    rst_n = 1'b0; tbl_we = 0; tbl_sel = 0; tbl_idx = 0; tbl_base = 0; tbl_limit = 0; tbl_acc = 0;
    req_valid = 0; req_prot = 0; req_wide = 0; req_seg = 0; req_off = 0; rsp_ready = 1;
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        m_base[t][i] = 0; m_lim[t][i] = 0; m_acc[t][i] = 0;
      end
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 reset req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: cleared tables read not present
    xl("R10 reset ldt1 absent", 1'b1, 1'b1, 16'h000C, 32'd0);
    xl("R10 reset gdt7 absent", 1'b1, 1'b1, 16'h0038, 32'd0);

    // R1 real mode sweep, incl. wrap past 1 MB and ignored high offset bits
    for (int s = 0; s < 16; s++)
      for (int o = 0; o < 4; o++) begin
        logic [15:0] sv;
        logic [31:0] ov;
        sv = 16'(s * 16'h1111);
        ov = {16'hDEAD, 16'(o * 16'h5555)};
        xl("R1 real", 1'b0, 1'b0, sv, ov);
      end
    xl("R1 real wrap", 1'b0, 1'b1, 16'hFFFF, 32'h0000FFFF);

    // load both tables; a few entries not present (R10 write)
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++)
        wr(1'(t), 3'(i), 32'h1000_0000 * (t + 1) + 32'h0012_3450 * i + 32'hFFFF_0000 * t,
           20'(i * 20'h1_1111 + 20'h10),
           ((t == 0 && i == 5) || (t == 1 && i == 6)) ? 8'h12 : 8'h92);

    // R2..R7 sweep over both tables, all entries, both widths, limit edges, rpl bits
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++)
        for (int w = 0; w < 2; w++)
          for (int k = 0; k < 4; k++) begin
            logic [15:0] sel;
            logic [31:0] ov;
            sel = {10'd0, 3'(i), 1'(t), 2'(k)};
            case (k)
              0: ov = 32'd0;
              1: ov = {12'd0, m_lim[t][i]};
              2: ov = {12'd0, m_lim[t][i]} + 32'd1;
              default: ov = 32'hABCD_0000 | {28'd0, 4'(i)};
            endcase
            xl("R2 R3 R4 R5 R6 prot", 1'b1, 1'(w), sel, ov);
          end
    // R7 range and priority
    xl("R7 index beyond table", 1'b1, 1'b1, 16'h0040, 32'd0);
    xl("R7 beyond ldt", 1'b1, 1'b0, 16'h8004, 32'd0);
    xl("R6 null with rpl", 1'b1, 1'b1, 16'h0003, 32'hFFFF_FFFF);
    // R2 wrap of base+offset
    wr(1'b1, 3'd2, 32'hFFFF_FFF0, 20'hF_FFFF, 8'h80);
    xl("R2 base wrap", 1'b1, 1'b1, 16'h0014, 32'h0000_0020);
    // R4 32-bit offset above any 20-bit limit
    xl("R4 wide over 20b", 1'b1, 1'b1, 16'h0014, 32'h0010_0000);

    // R10 write and request in the same cycle: old contents used
    e1 = model(1'b1, 1'b1, 16'h001C, 32'h10);
    @(negedge clk);
    tbl_we = 1; tbl_sel = 1; tbl_idx = 3; tbl_base = 32'h5555_0000; tbl_limit = 20'hFFF; tbl_acc = 8'h80;
    req_valid = 1; req_prot = 1; req_wide = 1; req_seg = 16'h001C; req_off = 32'h10; rsp_ready = 1;
    @(negedge clk);
    tbl_we = 0; req_valid = 0;
    m_base[1][3] = 32'h5555_0000; m_lim[1][3] = 20'hFFF; m_acc[1][3] = 8'h80;
    check("R10 same-cycle old code", 64'(rsp_code), 64'(e1[33:32]));
    check("R10 same-cycle old addr", 64'(rsp_addr), 64'(e1[31:0]));
    xl("R10 after write new", 1'b1, 1'b1, 16'h001C, 32'h10);

    // R9 back-pressure
    e1 = model(1'b0, 1'b0, 16'h1234, 32'h0000_0056);
    e2 = model(1'b0, 1'b0, 16'h0F00, 32'h0000_0001);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_prot = 0; req_wide = 0; req_seg = 16'h1234; req_off = 32'h56;
    @(negedge clk);
    req_seg = 16'h0F00; req_off = 32'h1;
    check("R9 stall valid", 64'(rsp_valid), 64'd1);
    check("R9 stall ready low", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    check("R9 stall hold addr", 64'(rsp_addr), 64'(e1[31:0]));
    check("R9 stall ready still low", 64'(req_ready), 64'd0);
    rsp_ready = 1;
    #1;
    check("R9 ready follows drain", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 0;
    check("R9 waiting request taken", 64'(rsp_addr), 64'(e2[31:0]));
    @(negedge clk);
    check("R9 drained", 64'(rsp_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule